// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block divides a fast input clock, standing in for the VCO-side signal of a frequency synthesizer, by a programmable integer N and emits one single-cycle pulse per completed division. The division is composed the way a dual-modulus prescaler system does it. A behavioural prescaler counts either P+1 or P input cycles. A swallow counter holds the modulus at P+1 for the first A prescaler cycles. A programmable counter ends the division after B prescaler cycles in total. The result is N = P·B + A. The modulus-control signal is brought out so the prescaler choice can be observed.

New A and B values are written into a holding latch through a one-cycle load strobe. The running counters pick them up only at the end of the division in progress, so a write never disturbs a division that has already started. A write whose B is below 3 or below A is refused. The latch keeps its last legal pair and a sticky error flag is raised. The enable input gates the whole divider. While it is low the outputs stay quiet and the counters sit preloaded from the latch. The first division begins with the first enabled clock. P is a build parameter (8, 16 or 32), and the counter widths follow from it.

Top module: `swallow_divider`

## Requirements
- R1: With A and B loaded, the interval between consecutive rising samples of `div_pulse` is exactly P·B + A input clock cycles (P = 16 by default; A field is 5/4/3 bits and B field 11/12/12 bits for P = 32/16/8).
- R2: `div_pulse` is high for exactly one clock cycle per division.
- R3: Within each division `mod_ctl` is high for A·(P+1) cycles, at the start of the division. It is never high in a division with A = 0.
- R4: A legal write accepted in the middle of a division does not change that division's length. The following division uses the new values.
- R5: A write with B < 3 or B < A sets `cfg_err` and leaves the divider running on the previous legal values. `cfg_err` stays high until reset.
- R6: B = A is legal (every prescaler cycle at P+1), and so is the smallest legal B of 3.
- R7: While `en` is low, `div_pulse` and `mod_ctl` stay low. Values written while disabled are used from the first enabled cycle, and the first pulse follows N enabled cycles after `en` rises.
- R8: After reset `div_pulse`, `mod_ctl` and `cfg_err` are low, and the divider runs with A = DEF_A and B = DEF_B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided input clock (VCO side) |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Divider enable; low holds the counters and silences outputs |
| ld_valid | input | 1 | One-cycle strobe writing `ld_a`/`ld_b` into the holding latch |
| ld_a | input | AW | Swallow count A (AW = 5/4/3 for P = 32/16/8) |
| ld_b | input | BW | Programmable count B (BW = 11 for P = 32, else 12) |
| mod_ctl | output | 1 | High while the prescaler runs at modulus P+1 |
| div_pulse | output | 1 | One-cycle pulse at the end of each division |
| cfg_err | output | 1 | Sticky flag for a refused (illegal) write |

## Verification
The pulse interval is measured for the reset pair, for random legal A/B pairs, and for the edge pairs A = 0, B = A and B = 3. These cases separate a correct P·B + A from off-by-one errors in the prescaler reload and in the swallow decrement. The modulus-control high time per division is measured alongside. It exposes a swallow count that runs one prescaler cycle long or short even when the total happens to match. A write placed mid-division, together with illegal writes, shows whether values are taken only at the division boundary and whether refused values leak into the counters. A disabled stretch with a write inside it checks quiet outputs and the exact first-pulse delay after enabling.

// File: rtl/swallow_pkg.sv
`timescale 1ns/1ps
package swallow_pkg;
    // Swallow (A) field width for a given prescaler modulus
    function automatic int a_bits(input int p);
        return (p >= 32) ? 5 : ((p >= 16) ? 4 : 3);
    endfunction

    // Programmable (B) field width for a given prescaler modulus
    function automatic int b_bits(input int p);
        return (p >= 32) ? 11 : 12;
    endfunction

    localparam int B_FLOOR = 3;
endpackage

// File: rtl/swallow_hold.sv
`timescale 1ns/1ps
module swallow_hold #(
    parameter int AW    = 4,
    parameter int BW    = 12,
    parameter int DEF_A = 2,
    parameter int DEF_B = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_valid,
    input  logic [AW-1:0] ld_a,
    input  logic [BW-1:0] ld_b,
    output logic [AW-1:0] hold_a,
    output logic [BW-1:0] hold_b,
    output logic          cfg_err
);
    typedef struct packed {
        logic [AW-1:0] a;
        logic [BW-1:0] b;
        logic          err;
    } hold_t;

    hold_t st_d, st_q;
    logic  legal;

    always_comb begin
        legal = (ld_b >= BW'(swallow_pkg::B_FLOOR)) &&
                (ld_b >= {{(BW-AW){1'b0}}, ld_a});
        st_d = st_q;
        if (ld_valid) begin
            if (legal) begin
                st_d.a = ld_a;
                st_d.b = ld_b;
            end else begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{a: AW'(DEF_A), b: BW'(DEF_B), err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_a  = st_q.a;
    assign hold_b  = st_q.b;
    assign cfg_err = st_q.err;
endmodule

// File: rtl/swallow_core.sv
`timescale 1ns/1ps
module swallow_core #(
    parameter int P     = 16,
    parameter int AW    = 4,
    parameter int BW    = 12,
    parameter int DEF_A = 2,
    parameter int DEF_B = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [AW-1:0] nxt_a,
    input  logic [BW-1:0] nxt_b,
    output logic          mod_ctl,
    output logic          div_pulse
);
    localparam int PW = $clog2(P + 2);
    localparam logic [PW-1:0] PRE_LONG  = PW'(P);
    localparam logic [PW-1:0] PRE_SHORT = PW'(P - 1);

    typedef struct packed {
        logic [PW-1:0] pre;
        logic [AW-1:0] a_rem;
        logic [BW-1:0] b_rem;
        logic          pulse;
    } core_t;

    core_t         c_d, c_q;
    logic [AW-1:0] a_step;

    always_comb begin
        c_d       = c_q;
        c_d.pulse = 1'b0;
        a_step    = (c_q.a_rem != '0) ? c_q.a_rem - 1'b1 : '0;
        if (!en) begin
            // parked: preload the next division from the latch
            c_d.a_rem = nxt_a;
            c_d.b_rem = nxt_b;
            c_d.pre   = (nxt_a != '0) ? PRE_LONG : PRE_SHORT;
        end else if (c_q.pre != '0) begin
            c_d.pre = c_q.pre - 1'b1;
        end else if (c_q.b_rem <= BW'(1)) begin
            // terminal: close this division, take latched values
            c_d.pulse = 1'b1;
            c_d.a_rem = nxt_a;
            c_d.b_rem = nxt_b;
            c_d.pre   = (nxt_a != '0) ? PRE_LONG : PRE_SHORT;
        end else begin
            c_d.b_rem = c_q.b_rem - 1'b1;
            c_d.a_rem = a_step;
            c_d.pre   = (a_step != '0) ? PRE_LONG : PRE_SHORT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{pre:   (DEF_A != 0) ? PRE_LONG : PRE_SHORT,
                     a_rem: AW'(DEF_A),
                     b_rem: BW'(DEF_B),
                     pulse: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign mod_ctl   = en && (c_q.a_rem != '0);
    assign div_pulse = c_q.pulse;
endmodule

// File: rtl/swallow_divider.sv
`timescale 1ns/1ps
module swallow_divider #(
    parameter int P     = 16,
    parameter int DEF_A = 2,
    parameter int DEF_B = 16,
    localparam int AW   = swallow_pkg::a_bits(P),
    localparam int BW   = swallow_pkg::b_bits(P)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          ld_valid,
    input  logic [AW-1:0] ld_a,
    input  logic [BW-1:0] ld_b,
    output logic          mod_ctl,
    output logic          div_pulse,
    output logic          cfg_err
);
    logic [AW-1:0] hold_a;
    logic [BW-1:0] hold_b;

    swallow_hold #(.AW(AW), .BW(BW), .DEF_A(DEF_A), .DEF_B(DEF_B)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_valid (ld_valid),
        .ld_a     (ld_a),
        .ld_b     (ld_b),
        .hold_a   (hold_a),
        .hold_b   (hold_b),
        .cfg_err  (cfg_err)
    );

    swallow_core #(.P(P), .AW(AW), .BW(BW), .DEF_A(DEF_A), .DEF_B(DEF_B)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .nxt_a     (hold_a),
        .nxt_b     (hold_b),
        .mod_ctl   (mod_ctl),
        .div_pulse (div_pulse)
    );
endmodule

// File: rtl/swallow_divider_chk.sv
`timescale 1ns/1ps
module swallow_divider_chk #(
    parameter int AW = 4,
    parameter int BW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          ld_valid,
    input logic [AW-1:0] ld_a,
    input logic [BW-1:0] ld_b,
    input logic          mod_ctl,
    input logic          div_pulse,
    input logic          cfg_err
);
    p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse);

    p_quiet_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !div_pulse);

    p_quiet_modctl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !mod_ctl);

    p_modctl_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod_ctl) |-> (div_pulse || $rose(en)));

    p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    p_err_raise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ((ld_b < BW'(3)) || (ld_b < {{(BW-AW){1'b0}}, ld_a}))) |=> cfg_err);
endmodule

bind swallow_divider swallow_divider_chk #(.AW(AW), .BW(BW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .ld_valid  (ld_valid),
    .ld_a      (ld_a),
    .ld_b      (ld_b),
    .mod_ctl   (mod_ctl),
    .div_pulse (div_pulse),
    .cfg_err   (cfg_err)
);

// File: tb/tb_swallow_divider.sv
`timescale 1ns/1ps
module tb_swallow_divider;
    localparam int P     = 16;
    localparam int DEF_A = 2;
    localparam int DEF_B = 16;
    localparam int AW    = 4;
    localparam int BW    = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic          ld_valid = 1'b0;
    logic [AW-1:0] ld_a = '0;
    logic [BW-1:0] ld_b = '0;
    logic          mod_ctl, div_pulse, cfg_err;

    int  checks = 0;
    int  fails  = 0;
    int  tick   = 0;
    int  mc_run = 0;
    int  mc_last = 0;

    swallow_divider #(.P(P), .DEF_A(DEF_A), .DEF_B(DEF_B)) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .ld_valid(ld_valid),
        .ld_a(ld_a), .ld_b(ld_b), .mod_ctl(mod_ctl),
        .div_pulse(div_pulse), .cfg_err(cfg_err)
    );

    always #10 clk = ~clk;

    always @(posedge clk) tick <= tick + 1;

    // per-division count of modulus-control samples
    always @(negedge clk) begin
        if (div_pulse) begin
            mc_last = mc_run;
            mc_run  = int'(mod_ctl);
        end else begin
            mc_run  = mc_run + int'(mod_ctl);
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_pulse(output int t);
        do @(negedge clk); while (!div_pulse);
        t = tick;
        #2;
    endtask

    task automatic write_cfg(input int a, input int b);
        @(negedge clk);
        ld_valid = 1'b1;
        ld_a = AW'(a);
        ld_b = BW'(b);
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    // measure one full division started after the write
    task automatic measure(input string tag, input int a, input int b);
        int t1, t2;
        wait_pulse(t1);
        wait_pulse(t2);
        check({tag, " period"}, t2 - t1, P * b + a);
        check({tag, " modctl"}, mc_last, a * (P + 1));
    endtask

    task automatic t_reset_r8();
        int t1, t2, hi;
        hi = 0;
        repeat (3) begin
            @(negedge clk);
            hi += int'(div_pulse) + int'(mod_ctl) + int'(cfg_err);
        end
        check("R8 outputs low in reset", hi, 0);
        rst_n = 1'b1;
        @(negedge clk);
        en = 1'b1;
        wait_pulse(t1);
        wait_pulse(t2);
        check("R8 default period", t2 - t1, P * DEF_B + DEF_A);
        check("R8 err clear", int'(cfg_err), 0);
    endtask

    task automatic t_pulse_width_r2();
        int t;
        wait_pulse(t);
        @(negedge clk);
        check("R2 pulse one cycle", int'(div_pulse), 0);
    endtask

    task automatic t_random_r1();
        for (int i = 0; i < 4; i++) begin
            int a, b;
            b = 3 + int'($urandom % 60);
            a = int'($urandom % 16);
            if (a > b) a = b;
            write_cfg(a, b);
            measure($sformatf("R1 R3 rand a=%0d b=%0d", a, b), a, b);
        end
    endtask

    task automatic t_edges_r6();
        write_cfg(15, 15);
        measure("R6 B==A", 15, 15);
        write_cfg(0, 3);
        measure("R6 R3 B=3 A=0", 0, 3);
        write_cfg(3, 3);
        measure("R6 B=3 A=3", 3, 3);
    endtask

    task automatic t_midwrite_r4();
        int t1, t2, t3;
        write_cfg(4, 20);
        measure("R4 base", 4, 20);
        wait_pulse(t1);
        repeat (40) @(negedge clk);
        write_cfg(9, 30);
        wait_pulse(t2);
        check("R4 current division kept", t2 - t1, P * 20 + 4);
        wait_pulse(t3);
        check("R4 next division new", t3 - t2, P * 30 + 9);
    endtask

    task automatic t_illegal_r5();
        write_cfg(1, 2);
        check("R5 err on B<3", int'(cfg_err), 1);
        measure("R5 old values kept", 9, 30);
        write_cfg(7, 5);
        measure("R5 old values kept B<A", 9, 30);
        write_cfg(2, 10);
        check("R5 err sticky", int'(cfg_err), 1);
        measure("R5 legal after err", 2, 10);
    endtask

    task automatic t_disable_r7();
        int bad, t0, t1;
        @(negedge clk);
        en = 1'b0;
        bad = 0;
        @(negedge clk);
        write_cfg(5, 10);
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            bad += int'(div_pulse) + int'(mod_ctl);
        end
        check("R7 quiet while disabled", bad, 0);
        en = 1'b1;
        t0 = tick;
        wait_pulse(t1);
        check("R7 first pulse after enable", t1 - t0, P * 10 + 5);
        wait_pulse(t0);
        check("R7 modctl after enable", mc_last, 5 * (P + 1));
    endtask

    initial begin
        t_reset_r8();
        t_pulse_width_r2();
        t_random_r1();
        t_edges_r6();
        t_midwrite_r4();
        t_illegal_r5();
        t_disable_r7();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule